// File: doc/BRIEF.md
# Cell-Granular Payload DMA with Endian Swap

This block is a bus-master DMA engine that moves one AAL5 packet payload between host memory and a device-side cell FIFO. The payload is cut into 48-byte cells, and each cell crosses the host bus as one master burst of 32-bit words. Words in host memory are little-endian and words in the cell FIFO are big-endian, so the byte lanes of every payload word are reversed in both directions.

A packet is started with a one-cycle `start` pulse that carries a direction, a host buffer address, a byte length and a completion-entry address. A transmit packet reads from the host and writes the FIFO. A receive packet pops the FIFO and writes the host. The engine raises `m_req` once for each cell and waits for a one-cycle `m_gnt`. It then presents beats with `m_valid`. A beat is taken on each cycle in which `m_rdy` is high, so the host may insert any number of wait states. When the payload is finished, the engine writes a four-word completion entry with one more burst and pulses `done`.

A length above 65535 bytes is refused. `len_err` pulses and no bus traffic follows.

Top module: `cell_burst_dma`

## Requirements
- R1: Each burst starts only after `m_gnt` has been seen while `m_req` was high. A payload burst has at most 12 accepted beats, and `m_last` marks its final beat.
- R2: Each payload word is byte-reversed: FIFO word {b0,b1,b2,b3} (b0 in bits 31:24) is host word {b3,b2,b1,b0}. This holds for transmit (`dir`=0, host to FIFO) and for receive (`dir`=1, FIFO to host).
- R3: The payload host address starts at `base_addr` and grows by 4 after each accepted beat, also across cells. It holds still during wait states.
- R4: A cell with r < 48 remaining bytes uses only ceil(r/4) bus beats. Every cell still makes exactly 12 FIFO operations: on transmit the unused words are written as zero, and on receive they are popped and dropped.
- R5: A `start` with `pkt_len` > 65535 gives a one-cycle `len_err` pulse on the next cycle. No request is raised and `busy` stays low.
- R6: After the last payload beat, a 4-beat write goes to `cmpl_addr`, +4, +8, +12, carrying these words in order: {dir, 15'b0, len[15:0]}; `base_addr`; the cell count; and the final host address (`base_addr` + 4*ceil(len/4)).
- R7: `done` pulses for one cycle, in the cycle after the last completion beat is accepted, and `busy` then falls.
- R8: A `start` while `busy` is high is ignored and does not change the packet in progress.
- R9: A zero-length packet moves no payload and only writes the completion entry (cell count 0).
- R10: After reset, `busy`, `done`, `len_err`, `m_req`, `m_valid` and both FIFO strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one packet (taken only when idle) |
| dir | input | 1 | 0 = host to FIFO, 1 = FIFO to host |
| base_addr | input | 32 | Host payload buffer address |
| pkt_len | input | 17 | Packet length in bytes |
| cmpl_addr | input | 32 | Host address of the completion entry |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle packet finish pulse |
| len_err | output | 1 | One-cycle length rejection pulse |
| m_req | output | 1 | Bus request for the next burst |
| m_gnt | input | 1 | One-cycle grant |
| m_valid | output | 1 | Beat presented |
| m_rdy | input | 1 | Beat accepted this cycle |
| m_we | output | 1 | Beat is a host write |
| m_last | output | 1 | Final beat of the burst |
| m_addr | output | 32 | Beat host address |
| m_wdata | output | 32 | Write beat data |
| m_rdata | input | 32 | Read beat data |
| fifo_wr_en | output | 1 | Push to transmit cell FIFO |
| fifo_wr_data | output | 32 | Big-endian word pushed |
| fifo_rd_en | output | 1 | Pop from receive cell FIFO |
| fifo_rd_data | input | 32 | Big-endian head word of receive FIFO |

## Verification
The hardest case to reach is a final partial cell while the host stalls. The engine must stop the bus burst after ceil(r/4) beats and still pad or drain the FIFO to 12 words, and addresses must stay frozen through the wait states. The bench reaches this with lengths such as 50 and 100 bytes, and it drives `m_rdy` low in a repeating pattern. It then checks the FIFO contents, the untouched host word just past the buffer, and the final address reported in the completion entry. A 65535-byte packet covers the top of the length range, and a stray `start` during a receive packet covers R8.

// File: rtl/cell_burst_dma.sv
module cell_burst_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 17,
  parameter int CELL_BYTES = 48,
  parameter int MAX_LEN = 65535
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] pkt_len,
  input  logic [AW-1:0] cmpl_addr,
  output logic          busy,
  output logic          done,
  output logic          len_err,
  output logic          m_req,
  input  logic          m_gnt,
  output logic          m_valid,
  input  logic          m_rdy,
  output logic          m_we,
  output logic          m_last,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wr_data,
  output logic          fifo_rd_en,
  input  logic [DW-1:0] fifo_rd_data
);
  localparam int BPW   = DW / 8;
  localparam int CWORDS = CELL_BYTES / BPW;
  localparam int CW    = $clog2(CWORDS + 1);
  localparam int ENTRY = 4;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_DAT, S_PAD, S_CREQ, S_CDAT, S_DONE} st_t;
  st_t st;

  logic [LW-1:0] rem;
  logic [AW-1:0] addr, base_q, cmpl_q;
  logic [15:0]   len_q, cells;
  logic          dir_q;
  logic [CW-1:0] bcnt, need;
  logic          err_q;

  function automatic logic [DW-1:0] lane_rev(input logic [DW-1:0] w);
    for (int i = 0; i < BPW; i++) lane_rev[8*i +: 8] = w[DW-8-8*i +: 8];
  endfunction

  wire [LW-1:0] rem_up = rem + LW'(BPW - 1);
  assign need = (rem >= LW'(CELL_BYTES)) ? CW'(CWORDS) : CW'(rem_up / LW'(BPW));

  wire accept   = (st == S_DAT) && m_rdy;
  wire fifo_op  = accept || (st == S_PAD);
  wire dat_last = (bcnt == need - 1'b1);
  wire pad_last = (bcnt == CW'(CWORDS - 1));
  wire cell_end = (accept && dat_last && need == CW'(CWORDS)) || ((st == S_PAD) && pad_last);
  wire more     = rem > LW'(CELL_BYTES);

  logic [DW-1:0] cword;
  always_comb begin
    case (bcnt[1:0])
      2'd0:    cword = DW'({dir_q, 15'b0, len_q});
      2'd1:    cword = DW'(base_q);
      2'd2:    cword = DW'(cells);
      default: cword = DW'(addr);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; addr <= '0; base_q <= '0; cmpl_q <= '0;
      len_q <= '0; cells <= '0; dir_q <= 1'b0; bcnt <= '0; err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (pkt_len > LW'(MAX_LEN)) err_q <= 1'b1;
          else begin
            rem <= pkt_len; addr <= base_addr; base_q <= base_addr;
            cmpl_q <= cmpl_addr; len_q <= pkt_len[15:0]; dir_q <= dir;
            cells <= '0; bcnt <= '0;
            st <= (pkt_len == '0) ? S_CREQ : S_REQ;
          end
        end
        S_REQ: if (m_gnt) begin st <= S_DAT; bcnt <= '0; end
        S_DAT: if (m_rdy) begin
          addr <= addr + AW'(BPW);
          if (!dat_last) bcnt <= bcnt + 1'b1;
          else if (need != CW'(CWORDS)) begin bcnt <= need; st <= S_PAD; end
        end
        S_PAD: if (!pad_last) bcnt <= bcnt + 1'b1;
        S_CREQ: if (m_gnt) begin st <= S_CDAT; bcnt <= '0; end
        S_CDAT: if (m_rdy) begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(ENTRY - 1)) st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (cell_end) begin
        cells <= cells + 1'b1;
        rem   <= more ? rem - LW'(CELL_BYTES) : '0;
        st    <= more ? S_REQ : S_CREQ;
      end
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign len_err  = err_q;
  assign m_req    = (st == S_REQ) || (st == S_CREQ);
  assign m_valid  = (st == S_DAT) || (st == S_CDAT);
  assign m_we     = ((st == S_DAT) && dir_q) || (st == S_CDAT);
  assign m_last   = ((st == S_DAT) && dat_last) || ((st == S_CDAT) && bcnt == CW'(ENTRY - 1));
  assign m_addr   = (st == S_CDAT) ? cmpl_q + AW'({bcnt, 2'b00}) : addr;
  assign m_wdata  = (st == S_CDAT) ? cword : lane_rev(fifo_rd_data);

  assign fifo_wr_en   = !dir_q && fifo_op;
  assign fifo_wr_data = (st == S_PAD) ? '0 : lane_rev(m_rdata);
  assign fifo_rd_en   = dir_q && fifo_op;
endmodule

// File: rtl/cell_burst_dma_chk.sv
module cell_burst_dma_chk #(
  parameter int AW = 32,
  parameter int LW = 17,
  parameter int MAX_LEN = 65535
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] pkt_len,
  input logic          busy,
  input logic          done,
  input logic          len_err,
  input logic          m_gnt,
  input logic          m_valid,
  input logic          m_rdy,
  input logic          m_we,
  input logic          m_last,
  input logic [AW-1:0] m_addr,
  input logic          fifo_wr_en,
  input logic          fifo_rd_en
);
  logic [4:0] beats;
  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (m_valid && m_rdy) beats <= m_last ? '0 : beats + 1'b1;
  end

  a_r1_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(m_gnt));
  a_r1_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> beats < 5'd12);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_rdy && !m_last) |=> (m_addr == $past(m_addr) + 32'd4));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_rdy) |=> $stable(m_addr));
  a_r4_fifo_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_en && fifo_rd_en));
  a_r5_len_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && pkt_len > LW'(MAX_LEN)) |=> (len_err && !busy));
  a_r7_done_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(m_valid && m_rdy && m_last && m_we));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind cell_burst_dma cell_burst_dma_chk chk_i (.*);

// File: tb/cell_burst_dma_tb_top.sv
module cell_burst_dma_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, dir = 0;
  logic [31:0] base_addr = 0, cmpl_addr = 0;
  logic [16:0] pkt_len = 0;
  logic busy, done, len_err, m_req, m_gnt, m_valid, m_rdy, m_we, m_last;
  logic [31:0] m_addr, m_wdata, m_rdata, fifo_wr_data, fifo_rd_data;
  logic fifo_wr_en, fifo_rd_en;

  cell_burst_dma dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int rdy_mode = 0;
  logic clr = 0;
  logic [31:0] mem [0:255];
  logic [31:0] txcap [0:63];
  int tx_n, rx_ptr, rd_beats, wr_beats, req_seen;
  int gcnt = 0, cyc = 0;

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] pat(input int i);
    return 32'h0302_0100 + 32'(i) * 32'h0404_0404;
  endfunction
  function automatic logic [31:0] rxw(input int i);
    return 32'hA5C3_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  assign m_rdata      = mem[m_addr[9:2]];
  assign fifo_rd_data = rxw(rx_ptr);

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      tx_n <= 0; rx_ptr <= 0; rd_beats <= 0; wr_beats <= 0; req_seen <= 0;
    end else begin
      if (m_valid && m_rdy && m_we) begin mem[m_addr[9:2]] <= m_wdata; wr_beats <= wr_beats + 1; end
      if (m_valid && m_rdy && !m_we) rd_beats <= rd_beats + 1;
      if (fifo_wr_en) begin txcap[tx_n % 64] <= fifo_wr_data; tx_n <= tx_n + 1; end
      if (fifo_rd_en) rx_ptr <= rx_ptr + 1;
      if (m_req) req_seen <= req_seen + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    m_gnt <= 1'b0;
    if (m_req && !m_gnt) begin
      if (gcnt == 2) begin m_gnt <= 1'b1; gcnt <= 0; end
      else gcnt <= gcnt + 1;
    end
    m_rdy <= (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 1);
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic launch(input logic d, input logic [31:0] b, input logic [16:0] l, input logic [31:0] c);
    @(negedge clk);
    dir = d; base_addr = b; pkt_len = l; cmpl_addr = c; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 100000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_entry(input string req, input logic d, input logic [31:0] b,
                             input int l, input logic [31:0] c);
    int idx = c[9:2];
    chk({req, " entry w0"}, mem[idx],   {d, 15'b0, 16'(l)});
    chk({req, " entry w1"}, mem[idx+1], b);
    chk({req, " entry w2"}, mem[idx+2], 32'((l + 47) / 48));
    chk({req, " entry w3"}, mem[idx+3], b + 32'(4 * ((l + 3) / 4)));
  endtask

  task automatic t_reset();
    chk("R10 busy", {31'b0, busy}, 0);
    chk("R10 done/err", {30'b0, done, len_err}, 0);
    chk("R10 req/valid", {30'b0, m_req, m_valid}, 0);
    chk("R10 fifo strobes", {30'b0, fifo_wr_en, fifo_rd_en}, 0);
  endtask

  task automatic t_tx_full();
    bit ok;
    clear(); rdy_mode = 0;
    launch(0, 32'h0, 17'd96, 32'h300);
    wait_done(ok);
    chk("R7 done seen", {31'b0, ok}, 1);
    @(negedge clk);
    chk("R7 busy low after done", {31'b0, busy}, 0);
    chk("R1 read beats 2 cells", rd_beats, 24);
    chk("R4 fifo pushes", tx_n, 24);
    for (int i = 0; i < 24; i++) chk("R2 tx swap", txcap[i], rev(pat(i)));
    check_entry("R6", 0, 32'h0, 96, 32'h300);
  endtask

  task automatic t_tx_partial();
    bit ok;
    clear(); rdy_mode = 1;
    launch(0, 32'h40, 17'd50, 32'h300);
    wait_done(ok);
    @(negedge clk);
    chk("R4 partial read beats", rd_beats, 13);
    chk("R4 partial fifo pushes", tx_n, 24);
    chk("R2 first word of cell 2", txcap[12], rev(pat(16 + 12)));
    for (int i = 13; i < 24; i++) chk("R4 zero pad", txcap[i], 0);
    check_entry("R3 R6 partial", 0, 32'h40, 50, 32'h300);
  endtask

  task automatic t_rx_waits();
    bit ok;
    clear(); rdy_mode = 1;
    launch(1, 32'h100, 17'd100, 32'h300);
    repeat (5) @(negedge clk);
    dir = 0; base_addr = 32'h0; pkt_len = 17'd48; start = 1;
    @(negedge clk); start = 0;
    wait_done(ok);
    @(negedge clk);
    chk("R8 host writes unchanged by stray start", wr_beats, 25 + 4);
    chk("R4 rx pops incl drain", rx_ptr, 36);
    chk("R8 no fifo pushes", tx_n, 0);
    for (int k = 0; k < 25; k++) chk("R2 rx swap", mem[64 + k], rev(rxw(k)));
    chk("R4 word past buffer untouched", mem[89], pat(89));
    check_entry("R6 rx", 1, 32'h100, 100, 32'h300);
  endtask

  task automatic t_len_err();
    clear();
    @(negedge clk);
    dir = 0; base_addr = 0; pkt_len = 17'd65536; cmpl_addr = 32'h300; start = 1;
    @(negedge clk); start = 0;
    chk("R5 len_err pulse", {31'b0, len_err}, 1);
    chk("R5 busy stays low", {31'b0, busy}, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, len_err}, 0);
    repeat (10) @(negedge clk);
    chk("R5 no request", req_seen, 0);
    chk("R5 no entry written", wr_beats, 0);
  endtask

  task automatic t_zero();
    bit ok;
    clear(); rdy_mode = 0;
    launch(1, 32'h80, 17'd0, 32'h300);
    wait_done(ok);
    @(negedge clk);
    chk("R9 done", {31'b0, ok}, 1);
    chk("R9 only entry writes", wr_beats, 4);
    chk("R9 no fifo pops", rx_ptr, 0);
    check_entry("R9", 1, 32'h80, 0, 32'h300);
  endtask

  task automatic t_max();
    bit ok;
    clear(); rdy_mode = 0;
    launch(0, 32'h0, 17'd65535, 32'h300);
    wait_done(ok);
    @(negedge clk);
    chk("R5 max length accepted", {31'b0, ok}, 1);
    chk("R1 max read beats", rd_beats, 16384);
    chk("R4 max fifo pushes", tx_n, 1366 * 12);
    chk("R6 max entry w0", mem[192], 32'h0000_FFFF);
    chk("R6 max entry w2", mem[194], 32'd1366);
    chk("R6 max entry w3", mem[195], 32'd65536);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tx_full();
    t_tx_partial();
    t_rx_waits();
    t_len_err();
    t_zero();
    t_max();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule